// File: doc/BRIEF.md
# JTAG Test Access Port with Boundary-Scan Chain

This block is the test access port of a small programmable logic device. It is clocked by TCK. A serial TMS/TDI/TDO interface steers the standard sixteen-state controller, which feeds a 4-bit instruction register and three data registers: a one-bit bypass stage, a 32-bit identification word and a boundary-scan chain. The chain has one cell for every dedicated input pin. Each bidirectional pin has two cells: one for its output data and one for its output enable.

There is no test-reset pin. The controller is forced into Test-Logic-Reset by the power-on reset input or by holding TMS high. The device offers five instructions: pin sampling with preload, external drive, bypass, identification and a high-impedance mode. During external drive and high-impedance mode, the core is cut off from the pins.

A programming engine outside the block reports the start and the completion of a programming session. If the port falls back to Test-Logic-Reset while a session is still open, a protection latch sets. While it is set, every pin driver is held off. The latch clears only on a completed session or a power-on reset.

Top module: `tapbs_top`

## Requirements
- R1: While `por_n` is low, and after it is released, the controller is in Test-Logic-Reset (state code 0), the identification instruction is active and `tdo_en` is low. No other input resets the port.
- R2: Five consecutive rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state, and this reselects the identification instruction.
- R3: State codes on `tap_state_o`: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR. Transitions follow the standard TMS-driven graph.
- R4: The instruction register is 4 bits wide. It loads 0001 in Capture-IR and shifts with bit 0 nearest TDO. The new instruction takes effect on the falling TCK edge in Update-IR.
- R5: Opcodes are 0000 external drive, 0010 sample/preload, 0011 identification, 0100 high-impedance and 1111 bypass. Every other code acts as bypass.
- R6: Identification captures the 32-bit value `IDCODE`, whose bit 0 is 1, and shifts it out least significant bit first.
- R7: The bypass stage captures 0 in Capture-DR. In Shift-DR, TDO then repeats TDI delayed by one TCK cycle.
- R8: `tdo` changes only on falling TCK edges. `tdo_en` is high only while the controller is in Shift-IR or Shift-DR.
- R9: The boundary chain is N_IN+2*N_IO bits long, with bit 0 nearest TDO. Bit i (i<N_IN) captures dedicated input i. Bit N_IN+2k captures the level on I/O pin k. Bit N_IN+2k+1 captures the core's enable for pin k. The chain is selected by sample/preload and by external drive.
- R10: Under sample/preload or external drive, the update stages of each I/O pin take the chain's data and enable bits on the falling TCK edge in Update-DR, and at no other time. Under external drive, the pins are driven from these stages.
- R11: Under identification, bypass and sample/preload, pins follow the core and the core sees the pins. Under external drive and high-impedance mode, every core-side input reads 0.
- R12: High-impedance mode turns off every pin enable and selects the bypass stage.
- R13: A session opens on `prog_start` and closes on `prog_done`. Reaching Test-Logic-Reset while a session is open sets the lock. The lock forces every pin enable low until `prog_done` or a power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Driver enable for tdo |
| tap_state_o | output | 4 | Controller state code |
| prog_start | input | 1 | Programming session start pulse |
| prog_done | input | 1 | Programming session completion pulse |
| din_pad | input | N_IN | Dedicated input pin levels |
| din_core | output | N_IN | Dedicated inputs as seen by the core |
| io_pin_i | input | N_IO | Levels on the I/O pins |
| io_pin_o | output | N_IO | Data driven onto the I/O pins |
| io_pin_oe | output | N_IO | Driver enables of the I/O pins |
| io_core_o | input | N_IO | Core output data |
| io_core_oe | input | N_IO | Core output enables |
| io_core_i | output | N_IO | I/O pin levels as seen by the core |

## Verification
The assertions assume three things about the inputs. TMS and TDI are stable around each rising TCK edge. `prog_start` and `prog_done` are single-cycle pulses synchronous to TCK and never high together. `por_n` stays low for at least one TCK edge. The stimulus meets these by changing TMS, TDI, the pin levels and the session pulses one nanosecond after a falling edge, and by holding each session pulse across exactly one rising edge. The pin and core levels stay constant through each scan so that captured values can be predicted.

// File: rtl/tapbs_pkg.sv
package tapbs_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    TS_RESET  = 4'd0,  TS_IDLE   = 4'd1,  TS_SEL_DR = 4'd2,  TS_CAP_DR = 4'd3,
    TS_SH_DR  = 4'd4,  TS_EX1_DR = 4'd5,  TS_PAU_DR = 4'd6,  TS_EX2_DR = 4'd7,
    TS_UPD_DR = 4'd8,  TS_SEL_IR = 4'd9,  TS_CAP_IR = 4'd10, TS_SH_IR  = 4'd11,
    TS_EX1_IR = 4'd12, TS_PAU_IR = 4'd13, TS_EX2_IR = 4'd14, TS_UPD_IR = 4'd15
  } tap_state_e;

  typedef enum logic [2:0] {
    INS_EXTEST, INS_SAMPLE, INS_IDCODE, INS_HIGHZ, INS_BYPASS
  } instr_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0010;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0011;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b0100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  // Unlisted opcodes fall through to bypass
  function automatic instr_e decode_op(input logic [IR_W-1:0] op);
    instr_e r;
    case (op)
      OP_EXTEST: r = INS_EXTEST;
      OP_SAMPLE: r = INS_SAMPLE;
      OP_IDCODE: r = INS_IDCODE;
      OP_HIGHZ:  r = INS_HIGHZ;
      default:   r = INS_BYPASS;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tapbs_fsm.sv
module tapbs_fsm
  import tapbs_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      TS_RESET:  state_d = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   state_d = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: state_d = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: state_d = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  state_d = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: state_d = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: state_d = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: state_d = tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: state_d = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: state_d = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: state_d = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  state_d = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: state_d = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: state_d = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: state_d = tms ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: state_d = tms ? TS_SEL_DR : TS_IDLE;
      default:   state_d = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= TS_RESET;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // Run length of TMS-high edges, saturating at five
  logic [2:0] tms_run_q;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                tms_run_q <= 3'd0;
    else if (!tms)             tms_run_q <= 3'd0;
    else if (tms_run_q != 3'd5) tms_run_q <= tms_run_q + 3'd1;
  end

  assert_five_ones_reset_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (tms_run_q == 3'd5) |-> (state_q == TS_RESET));

endmodule

// File: rtl/tapbs_ir.sv
module tapbs_ir
  import tapbs_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_e state,
  output logic       ir_so,
  output instr_e     instr
);

  logic [IR_W-1:0] sr_q, sr_d;
  logic [IR_W-1:0] op_q;
  logic            op_load, op_reset;

  always_comb begin
    sr_d = sr_q;
    if (state == TS_CAP_IR)     sr_d = IR_CAPTURE;
    else if (state == TS_SH_IR) sr_d = {tdi, sr_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) sr_q <= IR_CAPTURE;
    else        sr_q <= sr_d;
  end

  // Active instruction changes on the falling edge only
  assign op_reset = (state == TS_RESET);
  assign op_load  = (state == TS_UPD_IR);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)        op_q <= OP_IDCODE;
    else if (op_reset) op_q <= OP_IDCODE;
    else if (op_load)  op_q <= sr_q;
  end

  assign ir_so = sr_q[0];
  assign instr = decode_op(op_q);

  assert_ir_capture_R4: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_CAP_IR) |=> (sr_q == IR_CAPTURE));

endmodule

// File: rtl/tapbs_bsr.sv
module tapbs_bsr
  import tapbs_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int N_IO = 8
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  input  instr_e          instr,
  input  logic            lock,
  input  logic [N_IN-1:0] din_pad,
  output logic [N_IN-1:0] din_core,
  input  logic [N_IO-1:0] io_pin_i,
  output logic [N_IO-1:0] io_pin_o,
  output logic [N_IO-1:0] io_pin_oe,
  input  logic [N_IO-1:0] io_core_o,
  input  logic [N_IO-1:0] io_core_oe,
  output logic [N_IO-1:0] io_core_i,
  output logic            bsr_so
);

  localparam int LEN = N_IN + 2 * N_IO;

  logic [LEN-1:0]  cap_val, chain_q, chain_d;
  logic [N_IO-1:0] upd_dat_q, upd_oe_q;
  logic            sel, drive_ext, isolate, quiet;

  assign sel       = (instr == INS_SAMPLE) || (instr == INS_EXTEST);
  assign drive_ext = (instr == INS_EXTEST);
  assign isolate   = (instr == INS_EXTEST) || (instr == INS_HIGHZ);
  assign quiet     = lock || (instr == INS_HIGHZ);

  // Capture sources and core isolation for dedicated inputs
  for (genvar i = 0; i < N_IN; i++) begin : g_in_cell
    assign cap_val[i]  = din_pad[i];
    assign din_core[i] = isolate ? 1'b0 : din_pad[i];
  end

  // Two cells per I/O pin: data at even offset, enable at odd offset
  for (genvar k = 0; k < N_IO; k++) begin : g_io_cell
    localparam int DB = N_IN + 2 * k;
    localparam int EB = N_IN + 2 * k + 1;

    assign cap_val[DB] = io_pin_i[k];
    assign cap_val[EB] = io_core_oe[k];

    always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
        upd_dat_q[k] <= 1'b0;
        upd_oe_q[k]  <= 1'b0;
      end else if (sel && (state == TS_UPD_DR)) begin
        upd_dat_q[k] <= chain_q[DB];
        upd_oe_q[k]  <= chain_q[EB];
      end
    end

    assign io_pin_o[k]  = drive_ext ? upd_dat_q[k] : io_core_o[k];
    assign io_pin_oe[k] = quiet ? 1'b0 : (drive_ext ? upd_oe_q[k] : io_core_oe[k]);
    assign io_core_i[k] = isolate ? 1'b0 : io_pin_i[k];
  end

  always_comb begin
    chain_d = chain_q;
    if (sel && (state == TS_CAP_DR))     chain_d = cap_val;
    else if (sel && (state == TS_SH_DR)) chain_d = {tdi, chain_q[LEN-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign bsr_so = chain_q[0];

  assert_update_only_in_upd_R10: assert property (@(negedge tck) disable iff (!rst_n)
    ($past(state) != TS_UPD_DR) |-> ($stable(upd_dat_q) && $stable(upd_oe_q)));

  assert_core_isolated_R11: assert property (@(posedge tck) disable iff (!rst_n)
    isolate |-> ((din_core == '0) && (io_core_i == '0)));

  assert_highz_no_drive_R12: assert property (@(posedge tck) disable iff (!rst_n)
    (instr == INS_HIGHZ) |-> (io_pin_oe == '0));

endmodule

// File: rtl/tapbs_top.sv
module tapbs_top
  import tapbs_pkg::*;
#(
  parameter int              N_IN   = 4,
  parameter int              N_IO   = 8,
  parameter int              ID_W   = 32,
  parameter logic [ID_W-1:0] IDCODE = 32'h4C3A_E0B7
) (
  input  logic            tck,
  input  logic            por_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_en,
  output logic [3:0]      tap_state_o,
  input  logic            prog_start,
  input  logic            prog_done,
  input  logic [N_IN-1:0] din_pad,
  output logic [N_IN-1:0] din_core,
  input  logic [N_IO-1:0] io_pin_i,
  output logic [N_IO-1:0] io_pin_o,
  output logic [N_IO-1:0] io_pin_oe,
  input  logic [N_IO-1:0] io_core_o,
  input  logic [N_IO-1:0] io_core_oe,
  output logic [N_IO-1:0] io_core_i
);

  // Asynchronous assertion, synchronous release
  logic [1:0] por_sync_q;
  logic       rst_n;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) por_sync_q <= 2'b00;
    else        por_sync_q <= {por_sync_q[0], 1'b1};
  end
  assign rst_n = por_sync_q[1];

  tap_state_e state;
  instr_e     instr;
  logic       ir_so, bsr_so;

  tapbs_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  tapbs_ir u_ir (
    .tck   (tck),
    .rst_n (rst_n),
    .tdi   (tdi),
    .state (state),
    .ir_so (ir_so),
    .instr (instr)
  );

  // Protection latch for abandoned programming sessions
  logic session_q, session_d, lock_q, lock_d;
  always_comb begin
    session_d = session_q;
    lock_d    = lock_q;
    if (prog_done) begin
      session_d = 1'b0;
      lock_d    = 1'b0;
    end else begin
      if (prog_start) session_d = 1'b1;
      if (session_q && (state == TS_RESET)) lock_d = 1'b1;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      session_q <= 1'b0;
      lock_q    <= 1'b0;
    end else begin
      session_q <= session_d;
      lock_q    <= lock_d;
    end
  end

  tapbs_bsr #(.N_IN(N_IN), .N_IO(N_IO)) u_bsr (
    .tck        (tck),
    .rst_n      (rst_n),
    .tdi        (tdi),
    .state      (state),
    .instr      (instr),
    .lock       (lock_q),
    .din_pad    (din_pad),
    .din_core   (din_core),
    .io_pin_i   (io_pin_i),
    .io_pin_o   (io_pin_o),
    .io_pin_oe  (io_pin_oe),
    .io_core_o  (io_core_o),
    .io_core_oe (io_core_oe),
    .io_core_i  (io_core_i),
    .bsr_so     (bsr_so)
  );

  // Bypass and identification data registers
  logic            byp_sel, id_sel, bs_sel;
  logic            byp_q, byp_d;
  logic [ID_W-1:0] id_q, id_d;

  assign id_sel  = (instr == INS_IDCODE);
  assign bs_sel  = (instr == INS_SAMPLE) || (instr == INS_EXTEST);
  assign byp_sel = !(id_sel || bs_sel);

  always_comb begin
    byp_d = byp_q;
    id_d  = id_q;
    if (state == TS_CAP_DR) begin
      if (byp_sel) byp_d = 1'b0;
      if (id_sel)  id_d  = IDCODE;
    end else if (state == TS_SH_DR) begin
      if (byp_sel) byp_d = tdi;
      if (id_sel)  id_d  = {tdi, id_q[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      id_q  <= '0;
    end else begin
      byp_q <= byp_d;
      id_q  <= id_d;
    end
  end

  // Serial output, retimed to the falling edge
  logic tdo_d, tdo_en_d, tdo_q, tdo_en_q;
  always_comb begin
    tdo_d = 1'b0;
    if (state == TS_SH_IR) begin
      tdo_d = ir_so;
    end else if (state == TS_SH_DR) begin
      if (id_sel)      tdo_d = id_q[0];
      else if (bs_sel) tdo_d = bsr_so;
      else             tdo_d = byp_q;
    end
  end
  assign tdo_en_d = (state == TS_SH_IR) || (state == TS_SH_DR);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= tdo_d;
      tdo_en_q <= tdo_en_d;
    end
  end

  assign tdo         = tdo_q;
  assign tdo_en      = tdo_en_q;
  assign tap_state_o = state;

  assert_tdo_en_only_shift_R8: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en |-> ((state == TS_SH_IR) || (state == TS_SH_DR)));

  assert_bypass_captures_zero_R7: assert property (@(posedge tck) disable iff (!rst_n)
    ((state == TS_CAP_DR) && byp_sel) |=> !byp_q);

  assert_lock_from_reset_R13: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(state) == TS_RESET));

  assert_lock_drivers_off_R13: assert property (@(posedge tck) disable iff (!rst_n)
    lock_q |-> (io_pin_oe == '0));

endmodule

// File: tb/tapbs_top_tb.sv
`timescale 1ns/1ps
module tapbs_top_tb;

  localparam int          N_IN = 4;
  localparam int          N_IO = 8;
  localparam int          LEN  = N_IN + 2 * N_IO;
  localparam logic [31:0] IDC  = 32'h4C3A_E0B7;

  logic            tck = 1'b0;
  logic            por_n, tms, tdi, tdo, tdo_en;
  logic [3:0]      tap_state_o;
  logic            prog_start, prog_done;
  logic [N_IN-1:0] din_pad, din_core;
  logic [N_IO-1:0] io_pin_i, io_pin_o, io_pin_oe, io_core_o, io_core_oe, io_core_i;

  always #5 tck = ~tck;

  tapbs_top #(.N_IN(N_IN), .N_IO(N_IO), .ID_W(32), .IDCODE(IDC)) u_dut (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .tap_state_o(tap_state_o), .prog_start(prog_start), .prog_done(prog_done),
    .din_pad(din_pad), .din_core(din_core), .io_pin_i(io_pin_i), .io_pin_o(io_pin_o),
    .io_pin_oe(io_pin_oe), .io_core_o(io_core_o), .io_core_oe(io_core_oe),
    .io_core_i(io_core_i)
  );

  int    n_checks = 0;
  int    n_err    = 0;
  logic  smp_tdo, smp_en, mon_bit;
  logic  exp_b[$];
  string exp_tag[$];
  event  mon_ev;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // Scoreboard monitor: pops one expected TDO bit per sampled bit
  initial begin
    forever begin
      @(mon_ev);
      if (exp_b.size() == 0) check("scoreboard underflow", 1, 0);
      else check(exp_tag.pop_front(), mon_bit, exp_b.pop_front());
    end
  end

  initial begin
    #2_000_000;
    check("watchdog expired", 1, 0);
    report();
  end

  // One TCK cycle: drive after the falling edge, sample TDO before the rising edge
  task automatic clk(input logic m, input logic d);
    @(negedge tck); #1;
    tms = m; tdi = d;
    #3;
    smp_tdo = tdo; smp_en = tdo_en;
    @(posedge tck); #1;
  endtask

  task automatic walk(input logic m, input logic [3:0] exp, input string tag);
    clk(m, 1'b1);
    check(tag, tap_state_o, exp);
  endtask

  task automatic shift_ir(input logic [3:0] op, input bit chk);
    if (chk) for (int i = 0; i < 4; i++) begin
      exp_b.push_back(4'b0001 >> i);
      exp_tag.push_back("R4 IR capture bit");
    end
    clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);
    for (int i = 0; i < 4; i++) begin
      clk(i == 3, op[i]);
      if (chk) begin mon_bit = smp_tdo; ->mon_ev; end
    end
    clk(1, 0); clk(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, input bit chk,
                          input logic [63:0] expv, input string tag);
    if (chk) for (int i = 0; i < n; i++) begin
      exp_b.push_back(expv[i]);
      exp_tag.push_back(tag);
    end
    clk(1, 0); clk(0, 0); clk(0, 0);
    for (int i = 0; i < n; i++) begin
      clk(i == n - 1, din[i]);
      if (i == 0) check("R8 tdo_en high in Shift-DR", smp_en, 1);
      if (chk) begin mon_bit = smp_tdo; ->mon_ev; end
    end
    clk(1, 0); clk(0, 0);
    check("R8 tdo_en low outside shift", tdo_en, 0);
  endtask

  task automatic prog_pulse(input bit done);
    @(negedge tck); #1;
    if (done) prog_done = 1; else prog_start = 1;
    @(posedge tck); #1;
    prog_done = 0; prog_start = 0;
  endtask

  function automatic logic [63:0] cap_vec(input logic [N_IN-1:0] dp,
                                          input logic [N_IO-1:0] pi,
                                          input logic [N_IO-1:0] coe);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < N_IN; i++) v[i] = dp[i];
    for (int k = 0; k < N_IO; k++) begin
      v[N_IN + 2*k]     = pi[k];
      v[N_IN + 2*k + 1] = coe[k];
    end
    return v;
  endfunction

  function automatic logic [N_IO-1:0] pick(input logic [63:0] v, input int off);
    logic [N_IO-1:0] r;
    for (int k = 0; k < N_IO; k++) r[k] = v[N_IN + 2*k + off];
    return r;
  endfunction

  logic [63:0] pre_p, ext_q, bypd;

  initial begin
    por_n = 0; tms = 1; tdi = 0; prog_start = 0; prog_done = 0;
    din_pad = 4'b1010; io_pin_i = 8'hC5; io_core_o = 8'h96; io_core_oe = 8'h3C;
    pre_p = 64'h0_5A3C9; ext_q = 64'h0_C3E71;

    #23;
    check("R1 state during POR", tap_state_o, 0);
    check("R1 tdo_en during POR", tdo_en, 0);
    @(negedge tck); por_n = 1;
    repeat (3) @(posedge tck); #1;
    check("R1 state after POR", tap_state_o, 0);
    check("R11 pads follow core enable", io_pin_oe, io_core_oe);
    check("R11 pads follow core data", io_pin_o, io_core_o);
    check("R11 core sees dedicated inputs", din_core, din_pad);
    check("R11 core sees I/O pins", io_core_i, io_pin_i);

    // R1 R6: identification selected out of reset
    clk(0, 0);
    shift_dr(32, 64'h0, 1, {32'h0, IDC}, "R6 IDCODE after reset (R1)");

    // R3: walk the state graph
    walk(1, 2, "R3 Idle->Select-DR");   walk(1, 9, "R3 Select-DR->Select-IR");
    walk(0, 10, "R3 ->Capture-IR");     walk(0, 11, "R3 ->Shift-IR");
    walk(1, 12, "R3 ->Exit1-IR");       walk(0, 13, "R3 ->Pause-IR");
    walk(1, 14, "R3 ->Exit2-IR");       walk(1, 15, "R3 ->Update-IR");
    walk(1, 2, "R3 Update-IR->Select-DR"); walk(0, 3, "R3 ->Capture-DR");
    walk(1, 5, "R3 ->Exit1-DR");        walk(0, 6, "R3 ->Pause-DR");
    walk(1, 7, "R3 ->Exit2-DR");        walk(0, 4, "R3 Exit2-DR->Shift-DR");
    walk(1, 5, "R3 ->Exit1-DR again");  walk(1, 8, "R3 ->Update-DR");
    walk(0, 1, "R3 ->Idle");

    // R2: five TMS-high edges from Pause-DR
    clk(1, 0); clk(0, 0); clk(1, 0); clk(0, 0);
    check("R3 parked in Pause-DR", tap_state_o, 6);
    for (int i = 0; i < 5; i++) clk(1, 0);
    check("R2 Test-Logic-Reset after five ones", tap_state_o, 0);
    clk(0, 0);
    shift_dr(32, 64'h0, 1, {32'h0, IDC}, "R2 IDCODE reselected");

    // R4 R7: bypass with capture readout
    shift_ir(4'b1111, 1);
    bypd = 64'hB2;
    shift_dr(8, bypd, 1, {bypd[62:0], 1'b0}, "R7 bypass one-cycle delay");

    // R5: unlisted opcode behaves as bypass; 0011 selects identification
    shift_ir(4'b1010, 1);
    bypd = 64'h6;
    shift_dr(4, bypd, 1, {bypd[62:0], 1'b0}, "R5 unused opcode as bypass");
    shift_ir(4'b0011, 0);
    shift_dr(32, 64'h0, 1, {32'h0, IDC}, "R5 opcode 0011 selects IDCODE");

    // R9: sample/preload captures live values, pins keep following the core
    shift_ir(4'b0010, 0);
    check("R11 sample keeps core drive", io_pin_oe, io_core_oe);
    shift_dr(LEN, pre_p, 1, cap_vec(din_pad, io_pin_i, io_core_oe), "R9 sample capture");
    check("R10 preload does not drive under sample", io_pin_o, io_core_o);

    // R10 R11: external drive uses preloaded stages, core isolated
    shift_ir(4'b0000, 0);
    check("R10 extest data from preload", io_pin_o, pick(pre_p, 0));
    check("R10 extest enable from preload", io_pin_oe, pick(pre_p, 1));
    check("R11 extest isolates dedicated inputs", din_core, 0);
    check("R11 extest isolates I/O inputs", io_core_i, 0);
    din_pad = 4'b0101; io_pin_i = 8'h3A;
    shift_dr(LEN, ext_q, 1, cap_vec(din_pad, io_pin_i, io_core_oe), "R9 extest capture");
    check("R10 extest data after update", io_pin_o, pick(ext_q, 0));
    check("R10 extest enable after update", io_pin_oe, pick(ext_q, 1));

    // R12: high-impedance mode
    shift_ir(4'b0100, 0);
    check("R12 highz all enables off", io_pin_oe, 0);
    check("R11 highz isolates core", io_core_i, 0);
    bypd = 64'hD;
    shift_dr(4, bypd, 1, {bypd[62:0], 1'b0}, "R12 highz selects bypass");

    // R13: abandoned session locks the pins
    for (int i = 0; i < 5; i++) clk(1, 0);
    clk(0, 0);
    check("R13 drivers follow core before session", io_pin_oe, io_core_oe);
    prog_pulse(0);
    check("R13 open session alone no lock", io_pin_oe, io_core_oe);
    for (int i = 0; i < 5; i++) clk(1, 0);
    check("R13 lock forces enables off", io_pin_oe, 0);
    clk(0, 0);
    check("R13 lock holds in Idle", io_pin_oe, 0);
    prog_pulse(1);
    check("R13 completed session clears lock", io_pin_oe, io_core_oe);
    prog_pulse(0);
    for (int i = 0; i < 5; i++) clk(1, 0);
    check("R13 relocked", io_pin_oe, 0);
    @(negedge tck); por_n = 0;
    @(negedge tck); por_n = 1;
    repeat (3) @(posedge tck); #1;
    check("R13 power-on reset clears lock", io_pin_oe, io_core_oe);

    repeat (2) @(posedge tck);
    check("scoreboard drained", exp_b.size(), 0);
    report();
  end

endmodule